// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each issued operation takes an operation code, an accumulator-side operand, a memory-side operand and the carry currently held in the flag register. The block returns the result on the same cycle and, at the next clock edge, updates the sign (N), zero (Z), carry (C) and overflow (V) flags. Each operation has its own set of flags that it may change. Flags outside that set keep their value.

The operations are:
- add with carry and subtract with inverted borrow;
- bitwise AND, OR and XOR;
- shift left, shift right, rotate left and rotate right by one bit;
- increment and decrement by one;
- compare;
- bit test.

Compare and bit test only produce flags. For those two the write strobe stays low and the result port shows the accumulator operand unchanged. The block uses binary arithmetic only. The surrounding datapath decodes instructions and chooses the destination register.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after any reset, all four flags read 0.
- R2: Add (code 0) gives `a + m + C`. C takes the carry out. V is 1 when `a` and `m` have the same sign bit and the result's sign bit differs. N is result bit 7 and Z is 1 when the result is 0x00.
- R3: Subtract (code 1) gives `a - m - (1 - C)`, computed as `a + ~m + C`. C takes the carry out, so 1 means no borrow. V uses the rule of R2 with `~m` in place of `m`. N and Z are set as in R2.
- R4: AND (code 2), OR (code 3) and XOR (code 4) of `a` with `m` produce the result and update only N and Z. C and V hold their values.
- R5: Shift left (code 5) moves `a[7]` into C and fills bit 0 with 0. Shift right (code 6) moves `a[0]` into C and fills bit 7 with 0. Both update N, Z and C and hold V.
- R6: Rotate left (code 7) moves the old C into bit 0 and `a[7]` into C. Rotate right (code 8) moves the old C into bit 7 and `a[0]` into C. Both update N, Z and C and hold V.
- R7: Increment (code 9) and decrement (code 10) of `a` update only N and Z. C and V hold, even when the value wraps between 0xFF and 0x00.
- R8: Compare (code 11) forms `a - m` with no borrow-in and writes nothing back. C = 1 when `a >= m` (unsigned), Z = 1 when `a == m`, and N is bit 7 of the difference. V holds.
- R9: Bit test (code 12) sets N = `m[7]` and V = `m[6]`, and sets Z = 1 when `a AND m` is zero. C holds and nothing is written back.
- R10: When `op_en` is low, or the code is 13 to 15, no flag changes and `wr_result` is 0.
- R11: `wr_result` is 1 in the same cycle as an enabled operation with code 0 to 10, and `result` shows its value combinationally. For compare and bit test, `result` equals `a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| op_en | input | 1 | Issue strobe; the operation takes effect only while high |
| op_sel | input | 4 | Operation code, 0 to 12 (see requirements) |
| opnd_a | input | 8 | Accumulator-side operand (register being changed or compared) |
| opnd_m | input | 8 | Memory-side operand |
| result | output | 8 | Combinational operation result |
| wr_result | output | 1 | High when `result` should replace the destination |
| flag_n | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
At one clock edge the block both reads the carry flag as an operand and replaces that same flag. This happens in add, subtract and the two rotates. It also keeps untouched flags at their old values in that same edge. Before each vector the bench loads a known C and V with bit-test and compare operations, then issues the operation under test. It checks that the result port used the old carry and that the flags visible after the edge hold the new carry beside the preserved V.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ROTL = 4'd7,
        OP_ROTR = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_CMP  = 4'd11,
        OP_TST  = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam int NUM_FLAGS = $bits(flags_t);

    // Flags each operation may change.
    function automatic flags_t op_flag_mask(input alu_op_e op);
        flags_t m;
        case (op)
            OP_ADD, OP_SUB:                  m = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
            OP_AND, OP_OR, OP_XOR,
            OP_INC, OP_DEC:                  m = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
            OP_SHL, OP_SHR, OP_ROTL, OP_ROTR,
            OP_CMP:                          m = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
            OP_TST:                          m = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b1};
            default:                         m = '0;
        endcase
        return m;
    endfunction

    // Operations whose result replaces the destination.
    function automatic logic op_writes(input alu_op_e op);
        return (op <= OP_DEC);
    endfunction

    function automatic logic op_is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP) ||
               (op == OP_INC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   m,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b;
    logic         ci;

    // One shared adder; the operation chooses the second operand and carry-in.
    always_comb begin
        b  = m;
        ci = cin;
        unique case (op)
            OP_SUB:  b = ~m;
            OP_CMP:  begin b = ~m;        ci = 1'b1; end
            OP_INC:  begin b = '0;        ci = 1'b1; end
            OP_DEC:  begin b = '1;        ci = 1'b0; end
            default: begin b = m;         ci = cin;  end
        endcase
    end

    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        ovf         = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   m,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    localparam int MSB = W - 1;

    always_comb begin
        res  = a;
        cout = cin;
        unique case (op)
            OP_AND:  res = a & m;
            OP_OR:   res = a | m;
            OP_XOR:  res = a ^ m;
            OP_TST:  res = a & m;
            OP_SHL:  begin res = {a[MSB-1:0], 1'b0}; cout = a[MSB]; end
            OP_SHR:  begin res = {1'b0, a[MSB:1]};   cout = a[0];   end
            OP_ROTL: begin res = {a[MSB-1:0], cin};  cout = a[MSB]; end
            OP_ROTR: begin res = {cin, a[MSB:1]};    cout = a[0];   end
            default: begin res = a;                  cout = cin;    end
        endcase
    end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] upd_en,
    input  logic [NF-1:0] d,
    output logic [NF-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < NF; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else if (upd_en[i])
                    q[i] <= d[i];
            end

            AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_en[i] |=> $stable(q[i])); // R4
        end
    endgenerate

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_en,
    input  logic [3:0] op_sel,
    input  logic [7:0] opnd_a,
    input  logic [7:0] opnd_m,
    output logic [7:0] result,
    output logic       wr_result,
    output logic       flag_n,
    output logic       flag_z,
    output logic       flag_c,
    output logic       flag_v
);
    localparam int W   = 8;
    localparam int MSB = W - 1;

    alu_op_e      op;
    flags_t       cur, nxt, mask;
    logic [W-1:0] add_sum, bit_res, raw;
    logic         add_cout, add_ovf, bit_cout;

    assign op = alu_op_e'(op_sel);

    acc_alu_adder #(.W(W)) i_adder (
        .op   (op),
        .a    (opnd_a),
        .m    (opnd_m),
        .cin  (cur.c),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    acc_alu_bitops #(.W(W)) i_bitops (
        .op   (op),
        .a    (opnd_a),
        .m    (opnd_m),
        .cin  (cur.c),
        .res  (bit_res),
        .cout (bit_cout)
    );

    always_comb begin
        raw   = op_is_arith(op) ? add_sum : bit_res;
        nxt.n = (op == OP_TST) ? opnd_m[MSB]   : raw[MSB];
        nxt.z = (raw == '0);
        nxt.c = op_is_arith(op) ? add_cout     : bit_cout;
        nxt.v = (op == OP_TST) ? opnd_m[MSB-1] : add_ovf;
        mask  = op_en ? op_flag_mask(op) : '0;
    end

    assign result    = op_writes(op) ? raw : opnd_a;
    assign wr_result = op_en && op_writes(op);

    acc_alu_flags #(.NF(NUM_FLAGS)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_en (mask),
        .d      (nxt),
        .q      (cur)
    );

    assign flag_n = cur.n;
    assign flag_z = cur.z;
    assign flag_c = cur.c;
    assign flag_v = cur.v;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R10
    AST_LOGIC_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && (op_sel inside {4'd2, 4'd3, 4'd4}) |=> $stable(flag_c) && $stable(flag_v)); // R4
    AST_STEP_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && (op_sel inside {4'd9, 4'd10}) |=> $stable(flag_c)); // R7
    AST_CMP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op_sel == 4'd11 |=> flag_c == ($past(opnd_a) >= $past(opnd_m))); // R8
    AST_TEST_NV: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op_sel == 4'd12 |=> flag_n == $past(opnd_m[7]) && flag_v == $past(opnd_m[6])); // R9
    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op_sel <= 4'd10 |=> flag_z == ($past(result) == 8'h00)); // R2
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && (op_sel inside {4'd11, 4'd12}) |-> !wr_result && result == opnd_a); // R11

endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
    import acc_alu_pkg::*;

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  a;
        logic [7:0]  m;
        logic        ci;
        logic        vi;
        logic [7:0]  res;
        logic        wr;
        logic [3:0]  fl;   // {N,Z,C,V}
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  8'h50, 8'h50, 1'b0, 1'b0, 8'hA0, 1'b1, 4'b1001, "R2 "},
        '{4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 4'b0110, "R2 "},
        '{4'd0,  8'h10, 8'h20, 1'b1, 1'b1, 8'h31, 1'b1, 4'b0000, "R2 "},
        '{4'd1,  8'h50, 8'hB0, 1'b1, 1'b0, 8'hA0, 1'b1, 4'b1001, "R3 "},
        '{4'd1,  8'h05, 8'h05, 1'b0, 1'b0, 8'hFF, 1'b1, 4'b1000, "R3 "},
        '{4'd1,  8'h05, 8'h03, 1'b1, 1'b1, 8'h02, 1'b1, 4'b0010, "R3 "},
        '{4'd2,  8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 1'b1, 4'b0011, "R4 "},
        '{4'd3,  8'h80, 8'h01, 1'b0, 1'b0, 8'h81, 1'b1, 4'b1000, "R4 "},
        '{4'd4,  8'h5A, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b1, 4'b0110, "R4 "},
        '{4'd5,  8'h81, 8'h00, 1'b0, 1'b1, 8'h02, 1'b1, 4'b0011, "R5 "},
        '{4'd6,  8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'b0110, "R5 "},
        '{4'd7,  8'h40, 8'h00, 1'b1, 1'b0, 8'h81, 1'b1, 4'b1000, "R6 "},
        '{4'd8,  8'h01, 8'h00, 1'b1, 1'b1, 8'h80, 1'b1, 4'b1011, "R6 "},
        '{4'd8,  8'h02, 8'h00, 1'b0, 1'b0, 8'h01, 1'b1, 4'b0000, "R6 "},
        '{4'd9,  8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 4'b0101, "R7 "},
        '{4'd10, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 1'b1, 4'b1010, "R7 "},
        '{4'd9,  8'h7F, 8'h00, 1'b1, 1'b1, 8'h80, 1'b1, 4'b1011, "R7 "},
        '{4'd11, 8'h10, 8'h20, 1'b1, 1'b0, 8'h10, 1'b0, 4'b1000, "R8 "},
        '{4'd11, 8'h42, 8'h42, 1'b0, 1'b1, 8'h42, 1'b0, 4'b0111, "R8 "},
        '{4'd11, 8'hF0, 8'h10, 1'b0, 1'b0, 8'hF0, 1'b0, 4'b1010, "R8 "},
        '{4'd12, 8'h0F, 8'hC0, 1'b1, 1'b0, 8'h0F, 1'b0, 4'b1111, "R9 "},
        '{4'd12, 8'h01, 8'h01, 1'b0, 1'b1, 8'h01, 1'b0, 4'b0000, "R9 "}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_m = 8'h00;
    logic [7:0] result;
    logic       wr_result;
    logic       flag_n, flag_z, flag_c, flag_v;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    acc_alu i_acc_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_en     (op_en),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_m    (opnd_m),
        .result    (result),
        .wr_result (wr_result),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .flag_v    (flag_v)
    );

    function automatic logic [3:0] flags_now();
        return {flag_n, flag_z, flag_c, flag_v};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Issue one operation; returns the combinational outputs and the flags after the edge.
    task automatic do_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                         output logic [7:0] r, output logic w, output logic [3:0] f);
        @(negedge clk);
        op_en = 1'b1; op_sel = op; opnd_a = a; opnd_m = m;
        #1;
        r = result; w = wr_result;
        @(negedge clk);
        op_en = 1'b0;
        f = flags_now();
    endtask

    // Load known C and V using bit test and compare.
    task automatic preset(input logic c, input logic v);
        logic [7:0] r; logic w; logic [3:0] f;
        do_op(4'd12, 8'h00, v ? 8'h40 : 8'h00, r, w, f);
        if (c) do_op(4'd11, 8'h00, 8'h00, r, w, f);
        else   do_op(4'd11, 8'h00, 8'h01, r, w, f);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog expired act=0 exp=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] r; logic w; logic [3:0] f;

        repeat (3) @(negedge clk);
        chk("R1", "flags in reset", {4'h0, flags_now()}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "flags after reset", {4'h0, flags_now()}, 8'h00);

        // Table walk: preset C/V, issue, check result, strobe and flags.
        for (int i = 0; i < NV; i++) begin
            preset(VEC[i].ci, VEC[i].vi);
            do_op(VEC[i].op, VEC[i].a, VEC[i].m, r, w, f);
            chk($sformatf("%s", VEC[i].tag), $sformatf("result v%0d", i), r, VEC[i].res);
            chk($sformatf("%s", VEC[i].tag), $sformatf("wr v%0d", i), {7'h0, w}, {7'h0, VEC[i].wr});
            chk($sformatf("%s", VEC[i].tag), $sformatf("flags v%0d", i), {4'h0, f}, {4'h0, VEC[i].fl});
        end

        // R11: writing op presents its value with strobe high in the same cycle.
        preset(1'b0, 1'b0);
        do_op(4'd0, 8'h01, 8'h02, r, w, f);
        chk("R11", "add result", r, 8'h03);
        chk("R11", "add strobe", {7'h0, w}, 8'h01);

        // R10: idle cycles with live-looking inputs leave flags alone.
        preset(1'b1, 1'b1);  // flags now N0 Z1 C1 V1
        @(negedge clk);
        op_en = 1'b0; op_sel = 4'd0; opnd_a = 8'h80; opnd_m = 8'h80;
        #1;
        chk("R10", "idle strobe", {7'h0, wr_result}, 8'h00);
        repeat (2) @(negedge clk);
        chk("R10", "idle flags", {4'h0, flags_now()}, 8'h07);

        // R10: unused code with op_en high.
        do_op(4'd13, 8'h80, 8'h80, r, w, f);
        chk("R10", "unused strobe", {7'h0, w}, 8'h00);
        chk("R10", "unused flags", {4'h0, f}, 8'h07);
        do_op(4'd15, 8'h00, 8'hFF, r, w, f);
        chk("R10", "unused15 flags", {4'h0, f}, 8'h07);

        // R7: decrement through zero with carry clear keeps carry clear.
        preset(1'b0, 1'b1);
        do_op(4'd10, 8'h01, 8'h00, r, w, f);
        chk("R7", "dec to zero", {4'h0, f}, 8'h05);

        // R1: reset during operation clears all flags.
        preset(1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid-run reset", {4'h0, flags_now()}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule